// File: doc/BRIEF.md
# USB Device Bus-Power-State Controller

This block follows the upstream data lines of a USB 2.0 full-speed or low-speed device and decides when the device is awake, asleep, being reset or waking the host. It takes the raw single-ended receiver levels of D+ and D-, passes them through a synchroniser and decodes them into idle (J), K, single-ended zero (SE0) or SE1. The decoding depends on the speed-select input.

A single state machine, timed by a one-microsecond tick from the system, qualifies bus resets and enters suspend after a long idle stretch. It detects resume signalling and finishes it on a low-speed end-of-packet. When the device is configured and the host has allowed it, the block can also wake the host by requesting a K drive of fixed length. That request comes with an output-enable for the transceiver. The enable is dropped in the same cycle that the K drive ends.

The default timing uses 3000 ticks of continuous idle for suspend and 5000 ticks of idle before a remote wakeup may start. A reset is qualified after 3 ticks of SE0, and the K drive lasts 2000 ticks. Each of these is a parameter.

Top module: `usbpm_ctrl`

## Requirements
- R1: The {D+, D-} pair is decoded after synchronisation. 2'b00 is SE0 and 2'b11 is SE1. With `low_speed`=0, 2'b10 is idle (J) and 2'b01 is K. With `low_speed`=1 the two codes are swapped: 2'b01 is J and 2'b10 is K.
- R2: `suspended` rises only after SUSP_TICKS ticks of continuous J, from any awake state. Any non-J sample restarts the count, so a bus that shows K more often than that never suspends.
- R3: While suspended, K or SE1 begins resume signalling and `suspended` stays high. An SE0 shorter than a reset, followed by J, ends the resume and clears `suspended`.
- R4: SE0 that lasts RST_TICKS ticks qualifies a bus reset. This gives a one-cycle `bus_rst_pulse` and leaves `suspended` low. A reset is honoured while suspended as well.
- R5: `dflt_state` rises when the SE0 of a qualified reset ends. It falls when a new reset is qualified or while `dev_cfg` is high. Back-to-back resets each give their own pulse and their own return to `dflt_state`.
- R6: With `low_speed`=1, a short SE0 strobe every few ticks is bus activity and keeps the device awake.
- R7: A `wake_req` pulse is honoured only while suspended and while both `rwake_en` and `dev_cfg` are high. A pulse at any other time is dropped and is not kept for later.
- R8: `drive_k` never starts before HOLD_TICKS ticks of idle. A request that arrives earlier while suspended is held and served once that idle time is reached.
- R9: `drive_k` stays high for KDRV_TICKS ticks. `txoe` is high exactly when `drive_k` is high, and both fall in the same cycle. `suspended` stays high after the drive until resume ends.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| bus_lines | input | 2 | Raw receiver levels {D+, D-} |
| low_speed | input | 1 | 1 = low-speed line polarity, 0 = full-speed |
| rwake_en | input | 1 | Host has allowed remote wakeup |
| dev_cfg | input | 1 | Device is configured |
| wake_req | input | 1 | One-cycle request to wake the host |
| suspended | output | 1 | Device is in suspend (including resume and K drive) |
| bus_rst_pulse | output | 1 | One-cycle pulse when a bus reset is qualified |
| dflt_state | output | 1 | Device is in the default state after a reset |
| drive_k | output | 1 | Request to drive K upstream |
| txoe | output | 1 | Output enable for the upstream transceiver |

## Verification
The bench builds the block with SUSP_TICKS=40, HOLD_TICKS=60, RST_TICKS=3 and KDRV_TICKS=20, and sends a tick every fourth clock. With these values, full cycles of suspend, resume and remote wakeup fit within a few thousand clocks. The hold time stays longer than the suspend time, as it is with the defaults, so a wakeup request made just after suspend is entered falls inside the hold window and exercises the latch. A reset qualification of three ticks leaves room for a two-tick SE0 that ends a resume and a one-tick keep-alive strobe, both of which must not be taken for a reset.

// File: rtl/usbpm_pkg.sv
// Shared types for the bus-power-state controller: the decoded line state,
// the controller states and the polarity-aware line decoder.
package usbpm_pkg;

    typedef enum logic [1:0] {
        LN_SE0 = 2'd0,
        LN_J   = 2'd1,
        LN_K   = 2'd2,
        LN_SE1 = 2'd3
    } line_e;

    typedef enum logic [2:0] {
        ST_AWAKE  = 3'd0,
        ST_BUSRST = 3'd1,
        ST_SLEEP  = 3'd2,
        ST_RESUME = 3'd3,
        ST_WAKEK  = 3'd4
    } pm_state_e;

    // Idle (J) level of {D+, D-} for the selected speed.
    function automatic logic [1:0] idle_code(input logic ls_mode);
        return ls_mode ? 2'b01 : 2'b10;
    endfunction

    // Decode {D+, D-} into a line state; J and K swap with the speed.
    function automatic line_e decode_lines(input logic [1:0] dpdm, input logic ls_mode);
        line_e res;
        case (dpdm)
            2'b00:   res = LN_SE0;
            2'b11:   res = LN_SE1;
            2'b10:   res = ls_mode ? LN_K : LN_J;
            default: res = ls_mode ? LN_J : LN_K;
        endcase
        return res;
    endfunction

endpackage

// File: rtl/usbpm_line_sync.sv
// Synchroniser and decoder for the upstream data lines.
// Assumes bus_lines is asynchronous to clk. The two bits are synchronised
// raw and decoded only after the last stage. A skew between D+ and D-
// can therefore show up as at most one sample of SE0 or SE1, which the
// timers downstream absorb. The flops reset to the idle level of the
// selected speed.
module usbpm_line_sync
    import usbpm_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        low_speed,
    input  logic [1:0]  bus_lines,
    output line_e       line_o
);

    logic [STAGES-1:0][1:0] stg;

    // Shift the raw line pair through the synchroniser stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stg <= {STAGES{idle_code(low_speed)}};
        end else begin
            stg <= {stg[STAGES-2:0], bus_lines};
        end
    end

    // Decode the last stage with the current speed polarity.
    always_comb begin
        line_o = decode_lines(stg[STAGES-1], low_speed);
    end

endmodule

// File: rtl/usbpm_tick_cnt.sv
// Saturating microsecond counter.
// It counts tick pulses while clr is low and holds at LIMIT. clr has
// priority over the tick. The width is derived from LIMIT.
module usbpm_tick_cnt #(
    parameter  int LIMIT = 3000,
    localparam int W     = $clog2(LIMIT + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick,
    output logic [W-1:0] cnt
);

    localparam logic [W-1:0] CAP = W'(LIMIT);

    // Clear, count or hold the tick count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (tick && (cnt < CAP)) begin
            cnt <= cnt + W'(1);
        end
    end

endmodule

// File: rtl/usbpm_fsm.sv
// Power-state machine of the upstream port.
// Assumes the line state is already synchronised, and that the timer
// flags (suspend idle reached, wakeup hold reached, SE0 long enough for a
// reset, K drive complete) come from counters cleared by the top.
// Reset qualification outranks every state except the K drive, during
// which the port drives the line itself. Outputs are registered state
// or decoded from the state register.
module usbpm_fsm
    import usbpm_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  line_e ln,
    input  logic  susp_met,
    input  logic  hold_met,
    input  logic  se0_qual,
    input  logic  k_done,
    input  logic  rwake_en,
    input  logic  dev_cfg,
    input  logic  wake_req,
    output logic  suspended,
    output logic  bus_rst_pulse,
    output logic  dflt_state,
    output logic  drive_k,
    output logic  txoe
);

    pm_state_e st;
    logic      pend;
    logic      prev_se0;
    logic      wake_ok;

    assign wake_ok = rwake_en && dev_cfg;

    // State transitions, reset pulse, default-state flag and wakeup latch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st            <= ST_AWAKE;
            pend          <= 1'b0;
            prev_se0      <= 1'b0;
            bus_rst_pulse <= 1'b0;
            dflt_state    <= 1'b0;
        end else begin
            prev_se0      <= (ln == LN_SE0);
            bus_rst_pulse <= 1'b0;
            if (se0_qual && (st != ST_BUSRST) && (st != ST_WAKEK)) begin
                st            <= ST_BUSRST;
                bus_rst_pulse <= 1'b1;
                dflt_state    <= 1'b0;
            end else begin
                case (st)
                    ST_AWAKE: begin
                        if (susp_met) st <= ST_SLEEP;
                    end
                    ST_BUSRST: begin
                        if (ln != LN_SE0) begin
                            st         <= ST_AWAKE;
                            dflt_state <= 1'b1;
                        end
                    end
                    ST_SLEEP: begin
                        if ((ln == LN_K) || (ln == LN_SE1)) begin
                            st <= ST_RESUME;
                        end else if (prev_se0 && (ln == LN_J)) begin
                            st <= ST_AWAKE;
                        end else if (pend && hold_met && wake_ok) begin
                            st <= ST_WAKEK;
                        end
                    end
                    ST_RESUME: begin
                        if (prev_se0 && (ln == LN_J)) begin
                            st <= ST_AWAKE;
                        end else if (susp_met) begin
                            st <= ST_SLEEP;
                        end
                    end
                    ST_WAKEK: begin
                        if (k_done) st <= ST_RESUME;
                    end
                    default: st <= ST_AWAKE;
                endcase
            end
            if (dev_cfg) dflt_state <= 1'b0;
            if (st != ST_SLEEP) begin
                pend <= 1'b0;
            end else if (wake_req && wake_ok) begin
                pend <= 1'b1;
            end
        end
    end

    // Decode the externally visible state flags.
    always_comb begin
        suspended = (st == ST_SLEEP) || (st == ST_RESUME) || (st == ST_WAKEK);
        drive_k   = (st == ST_WAKEK);
        txoe      = drive_k;
    end

    // R4: the reset indication lasts exactly one cycle
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_pulse |=> !bus_rst_pulse);

    // R4: a qualified reset always leaves the port awake
    p_pulse_wakes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rst_pulse |-> !suspended);

    // R2: suspend is entered only once the idle timer has reached its limit
    p_sleep_needs_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(suspended) |-> $past(susp_met));

    // R8: the K drive never starts inside the idle hold window
    p_hold_before_k_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_k) |-> $past(hold_met));

    // R7: the K drive needs both permission and configuration
    p_k_needs_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drive_k) |-> $past(rwake_en && dev_cfg));

    // R9: the K drive ends only when its timer has run out
    p_k_full_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_k) |-> $past(k_done));

    // R9: after the drive the port is still suspended, awaiting resume end
    p_k_stays_asleep_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(drive_k) |-> suspended);

endmodule

// File: rtl/usbpm_ctrl.sv
// Top of the bus-power-state controller of a USB device upstream port.
// Assumes us_tick is a one-cycle pulse once per microsecond in the clk
// domain, and that wake_req is a one-cycle pulse in the same domain.
// It builds the synchroniser, three saturating tick counters (continuous
// idle, continuous SE0, K drive length) and the state machine.
module usbpm_ctrl
    import usbpm_pkg::*;
#(
    parameter int SUSP_TICKS  = 3000,
    parameter int HOLD_TICKS  = 5000,
    parameter int RST_TICKS   = 3,
    parameter int KDRV_TICKS  = 2000,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       us_tick,
    input  logic [1:0] bus_lines,
    input  logic       low_speed,
    input  logic       rwake_en,
    input  logic       dev_cfg,
    input  logic       wake_req,
    output logic       suspended,
    output logic       bus_rst_pulse,
    output logic       dflt_state,
    output logic       drive_k,
    output logic       txoe
);

    localparam int IDLE_LIM = (SUSP_TICKS > HOLD_TICKS) ? SUSP_TICKS : HOLD_TICKS;
    localparam int IDLE_W   = $clog2(IDLE_LIM + 1);
    localparam int SE0_W    = $clog2(RST_TICKS + 1);
    localparam int KD_W     = $clog2(KDRV_TICKS + 1);

    line_e             ln;
    logic [IDLE_W-1:0] idle_cnt;
    logic [SE0_W-1:0]  se0_cnt;
    logic [KD_W-1:0]   kd_cnt;
    logic              susp_met;
    logic              hold_met;
    logic              se0_qual;
    logic              k_done;

    usbpm_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .low_speed (low_speed),
        .bus_lines (bus_lines),
        .line_o    (ln)
    );

    // The idle timer restarts on any non-J sample and while K is driven.
    usbpm_tick_cnt #(.LIMIT(IDLE_LIM)) u_idle (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   ((ln != LN_J) || drive_k),
        .tick  (us_tick),
        .cnt   (idle_cnt)
    );

    usbpm_tick_cnt #(.LIMIT(RST_TICKS)) u_se0 (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (ln != LN_SE0),
        .tick  (us_tick),
        .cnt   (se0_cnt)
    );

    usbpm_tick_cnt #(.LIMIT(KDRV_TICKS)) u_kdrv (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!drive_k),
        .tick  (us_tick),
        .cnt   (kd_cnt)
    );

    // Compare the counters against their thresholds.
    always_comb begin
        susp_met = (idle_cnt >= IDLE_W'(SUSP_TICKS));
        hold_met = (idle_cnt >= IDLE_W'(HOLD_TICKS));
        se0_qual = (se0_cnt  >= SE0_W'(RST_TICKS));
        k_done   = (kd_cnt   >= KD_W'(KDRV_TICKS));
    end

    usbpm_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .ln            (ln),
        .susp_met      (susp_met),
        .hold_met      (hold_met),
        .se0_qual      (se0_qual),
        .k_done        (k_done),
        .rwake_en      (rwake_en),
        .dev_cfg       (dev_cfg),
        .wake_req      (wake_req),
        .suspended     (suspended),
        .bus_rst_pulse (bus_rst_pulse),
        .dflt_state    (dflt_state),
        .drive_k       (drive_k),
        .txoe          (txoe)
    );

endmodule

// File: tb/usbpm_ctrl_bench.sv
// Bench for usbpm_ctrl with short timing parameters and a tick every
// fourth clock. A vector table walks suspend, resume and reset; directed
// tests then cover polarity, keep-alive and remote wakeup.
module usbpm_ctrl_bench;

    localparam int SUSP = 40;
    localparam int HOLD = 60;
    localparam int RSTQ = 3;
    localparam int KDRV = 20;
    localparam int TDIV = 4;

    localparam int SYM_J = 0;
    localparam int SYM_K = 1;
    localparam int SYM_0 = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       us_tick = 1'b0;
    logic [1:0] bus_lines = 2'b10;
    logic       low_speed = 1'b0;
    logic       rwake_en = 1'b0;
    logic       dev_cfg = 1'b0;
    logic       wake_req = 1'b0;
    logic       suspended;
    logic       bus_rst_pulse;
    logic       dflt_state;
    logic       drive_k;
    logic       txoe;

    int nchk = 0;
    int nerr = 0;
    int npulse = 0;
    int run = 0;
    int maxrun = 0;
    int tdiv = 0;
    bit done = 1'b0;

    usbpm_ctrl #(
        .SUSP_TICKS (SUSP),
        .HOLD_TICKS (HOLD),
        .RST_TICKS  (RSTQ),
        .KDRV_TICKS (KDRV)
    ) u_usbpm_ctrl (
        .clk           (clk),
        .rst_n         (rst_n),
        .us_tick       (us_tick),
        .bus_lines     (bus_lines),
        .low_speed     (low_speed),
        .rwake_en      (rwake_en),
        .dev_cfg       (dev_cfg),
        .wake_req      (wake_req),
        .suspended     (suspended),
        .bus_rst_pulse (bus_rst_pulse),
        .dflt_state    (dflt_state),
        .drive_k       (drive_k),
        .txoe          (txoe)
    );

    always #10 clk = ~clk;

    always @(posedge clk) begin
        tdiv    <= (tdiv == TDIV - 1) ? 0 : tdiv + 1;
        us_tick <= (tdiv == TDIV - 1);
    end

    // Count reset pulses and their longest run.
    always @(negedge clk) begin
        if (rst_n && bus_rst_pulse) begin
            npulse = npulse + 1;
            run = run + 1;
            if (run > maxrun) maxrun = run;
        end else begin
            run = 0;
        end
    end

    // Vector table: line symbol, ticks to hold it, expected suspended, expected dflt_state, requirement number.
    localparam int NVEC = 12;
    localparam int VEC [NVEC][5] = '{
        '{SYM_J, 20, 0, 0, 2},
        '{SYM_J, 25, 1, 0, 2},
        '{SYM_K,  5, 1, 0, 3},
        '{SYM_0,  2, 1, 0, 3},
        '{SYM_J,  2, 0, 0, 3},
        '{SYM_0, 10, 0, 0, 4},
        '{SYM_J,  2, 0, 1, 5},
        '{SYM_0, 10, 0, 0, 5},
        '{SYM_J,  2, 0, 1, 5},
        '{SYM_J, 45, 1, 1, 2},
        '{SYM_0, 10, 0, 0, 4},
        '{SYM_J,  2, 0, 1, 5}
    };

    function automatic logic [1:0] code(input int s, input logic ls);
        if (s == SYM_J) return ls ? 2'b01 : 2'b10;
        if (s == SYM_K) return ls ? 2'b10 : 2'b01;
        return 2'b00;
    endfunction

    task automatic drive(input int s);
        @(negedge clk);
        bus_lines = code(s, low_speed);
    endtask

    task automatic ticks(input int n);
        repeat (n * TDIV) @(negedge clk);
    endtask

    task automatic hold(input int s, input int n);
        drive(s);
        ticks(n);
    endtask

    task automatic pulse_wake();
        @(negedge clk);
        wake_req = 1'b1;
        @(negedge clk);
        wake_req = 1'b0;
    endtask

    task automatic chk(input string what, input int act, input int exp);
        nchk = nchk + 1;
        if (act != exp) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic chk_rng(input string what, input int act, input int lo, input int hi);
        nchk = nchk + 1;
        if ((act < lo) || (act > hi)) begin
            nerr = nerr + 1;
            $display("FAIL %s actual=%0d expected=%0d..%0d", what, act, lo, hi);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R2 reset: suspended", int'(suspended), 0);
        chk("R5 reset: dflt_state", int'(dflt_state), 0);
        chk("R9 reset: drive_k", int'(drive_k), 0);
        chk("R9 reset: txoe", int'(txoe), 0);
        chk("R4 reset: bus_rst_pulse", int'(bus_rst_pulse), 0);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            hold(VEC[i][0], VEC[i][1]);
            chk($sformatf("R%0d vector %0d suspended", VEC[i][4], i), int'(suspended), VEC[i][2]);
            chk($sformatf("R%0d vector %0d dflt_state", VEC[i][4], i), int'(dflt_state), VEC[i][3]);
        end
        chk("R4 reset pulses from table", npulse, 3);
        chk("R4 reset pulse length", maxrun, 1);

        // R1: full-speed 2'b01 is K, so it is activity
        bus_lines = 2'b01;
        ticks(50);
        chk("R1 FS 01 is K, stays awake", int'(suspended), 0);
        // R1: low-speed 2'b01 is J, so it is idle
        low_speed = 1'b1;
        ticks(50);
        chk("R1 LS 01 is J, suspends", int'(suspended), 1);
        // R3: low-speed resume then end-of-packet
        hold(SYM_K, 3);
        chk("R3 LS K keeps suspended", int'(suspended), 1);
        hold(SYM_0, 2);
        hold(SYM_J, 2);
        chk("R3 LS EOP ends resume", int'(suspended), 0);

        // R6: keep-alive strobes hold the device awake
        for (int s = 0; s < 6; s++) begin
            hold(SYM_0, 1);
            hold(SYM_J, 15);
        end
        chk("R6 keep-alive keeps awake", int'(suspended), 0);
        chk("R6 keep-alive not a reset", int'(dflt_state), 1);
        ticks(45);
        chk("R6 no strobes then suspends", int'(suspended), 1);

        // back to full speed, reset to wake up
        low_speed = 1'b0;
        hold(SYM_0, 10);
        hold(SYM_J, 2);
        chk("R4 reset honoured in suspend", int'(suspended), 0);
        chk("R5 default after reset", int'(dflt_state), 1);
        dev_cfg = 1'b1;
        rwake_en = 1'b1;
        repeat (2) @(negedge clk);
        chk("R5 configured clears default", int'(dflt_state), 0);

        // R7: request while awake is dropped
        pulse_wake();
        ticks(45);
        chk("R7 suspended for ignored request", int'(suspended), 1);
        ticks(30);
        chk("R7 awake request not kept", int'(drive_k), 0);

        // R7: request while disabled is dropped
        rwake_en = 1'b0;
        pulse_wake();
        ticks(5);
        chk("R7 disabled request no drive", int'(drive_k), 0);
        rwake_en = 1'b1;
        ticks(5);
        chk("R7 disabled request not kept", int'(drive_k), 0);

        // leave suspend by resume, then re-enter with a short idle
        hold(SYM_K, 2);
        hold(SYM_0, 2);
        hold(SYM_J, 2);
        chk("R3 FS resume ends", int'(suspended), 0);
        ticks(42);
        chk("R2 suspended before hold", int'(suspended), 1);
        pulse_wake();
        ticks(8);
        chk("R8 early request waits", int'(drive_k), 0);
        begin
            int w = 0;
            int len = 0;
            int mism = 0;
            while (!drive_k && (w < 200)) begin
                @(negedge clk);
                w = w + 1;
            end
            chk_rng("R8 latched request served", w, 8, 60);
            while (drive_k && (len < 400)) begin
                if (txoe !== drive_k) mism = mism + 1;
                @(negedge clk);
                len = len + 1;
            end
            chk_rng("R9 K drive length cycles", len, 76, 84);
            chk("R9 txoe follows drive_k", mism, 0);
        end
        chk("R9 txoe off after drive", int'(txoe), 0);
        chk("R9 suspended after drive", int'(suspended), 1);
        hold(SYM_K, 2);
        hold(SYM_0, 2);
        hold(SYM_J, 2);
        chk("R3 resume ends after wakeup", int'(suspended), 0);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            nchk = nchk + 1;
            nerr = nerr + 1;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

endmodule